// File: doc/BRIEF.md
# Chopped Two-Phase Conversion Sequencer

This block sequences the conversions of an oversampling converter front end so that amplifier and converter offset cancel out. Each conversion is split into two half-conversions. Between them the input multiplexer swaps which member of the selected channel pair drives the positive path. The result is the positive-phase half-result minus the negative-phase half-result. The block watches the serial port's chip select and the falling edges of its serial clock. A newly written channel pair is put onto the multiplexer at a fixed edge of the frame, and conversion starts at a later edge, so the amplifiers have time to slew between the two.

The half-conversion length is a base count of system clocks shifted left by an oversampling selector. An external decimation stage is told when each half ends. It returns that half's result over a valid/data strobe. In single-rate mode the two halves run back to back. In double-rate mode the multiplexer reverses after every half and waits for a programmed settling interval. While chip select stays high, the block keeps producing halves, and each new half yields a result from the two most recent half-results. Keeping every other such result gives the single-rate data rate.

Top module: `azc_chop_sequencer`

## Requirements
- R1: After reset, `mux_chan` is 0, `mux_swap` is 0 (normal polarity), and `busy`, `half_run` and `res_valid` are all 0.
- R2: A channel pair written with `cfg_wr` is driven onto `mux_chan` on the 13th falling `sck` edge of a frame, and `mux_swap` is cleared at the same time. Before that edge, `mux_chan` does not change. A write in the same clock as the 13th edge is held until the next frame.
- R3: The 32nd falling `sck` edge of a frame starts a conversion: `busy` and `half_run` rise one clock after that edge is sampled. A frame with fewer edges starts nothing.
- R4: Each half-conversion keeps `half_run` high for `HALF_BASE << cfg_osr` clocks, with `cfg_osr` sampled at conversion start. In single-rate mode the two halves form one unbroken run of twice that length.
- R5: In single-rate mode, `mux_swap` inverts at mid-conversion and inverts again at the end, so it reads 1 after the first `half_done` and 0 after the second. Exactly one result is produced per conversion.
- R6: Each result on `res_data` (DW+1 bits, signed) is the half-result taken with `mux_swap` = 0 minus the one taken with `mux_swap` = 1, whichever came first.
- R7: In double-rate mode, `mux_swap` inverts after every half. `half_run` stays low for `settle_cycles + 1` clocks between the first two halves.
- R8: In double-rate mode, while `cs_n` stays high, further halves follow, each giving one result from the two most recent half-results. If `cs_n` is low when a half would start, the stream stops and the block goes idle.
- R9: `busy` stays high from conversion start until the result is valid. While `busy` is high, `sck` edges are not counted, so a pending channel pair is not applied.
- R10: Deasserting `cs_n` clears the frame's edge count, so edges from separate frames never add up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low, synchronous to clk |
| sck | input | 1 | Serial clock level, synchronous to clk |
| cfg_wr | input | 1 | Strobe: latch a new channel pair |
| cfg_chan | input | CH_W | Channel pair to latch |
| cfg_dbl | input | 1 | 1 selects double-rate mode, sampled at start |
| cfg_osr | input | OSR_W | Oversampling selector, sampled at start |
| settle_cycles | input | SET_W | Settling interval in clocks for double-rate mode |
| half_valid | input | 1 | Half-result strobe from the decimator |
| half_data | input | DW | Signed half-result |
| mux_chan | output | CH_W | Channel pair applied to the multiplexer |
| mux_swap | output | 1 | 1 when the pair's inputs are crossed |
| busy | output | 1 | Conversion in progress |
| half_run | output | 1 | A half-conversion is integrating |
| half_done | output | 1 | One-clock pulse at the end of each half |
| res_valid | output | 1 | One-clock result strobe |
| res_data | output | DW+1 | Signed offset-cancelled result |

## Verification
The collision that matters is a channel write landing in the same clock that the 13th falling edge is sampled. Here the pair already pending must be the one compared and applied, and the new one must wait for the next frame. The bench provokes this by raising `cfg_wr` in the clock where `sck` falls for the 13th time, with the pending pair equal to the applied one. It judges the outcome by checking that `mux_chan` is unchanged after that edge, and that it takes the new pair on the 13th edge of the following frame.

// File: rtl/azc_pkg.sv
// Shared types for the chopped conversion sequencer.
package azc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,        // waiting for a frame to start a conversion
        ST_HALF,        // a half-conversion is integrating
        ST_SETTLE_MID,  // double-rate settling between the two halves
        ST_WAIT_RES,    // waiting for the difference result
        ST_SETTLE_NEXT  // double-rate settling before a streamed half
    } seq_state_t;
endpackage

// File: rtl/azc_frame_watch.sv
// Counts falling serial-clock edges inside a chip-select frame and flags
// the apply edge and the start edge.
// Assumes cs_n and sck are already synchronous to clk and much slower.
module azc_frame_watch #(
    parameter int CNT_W      = 6,
    parameter int APPLY_EDGE = 13,
    parameter int START_EDGE = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic hold,
    output logic apply_hit,
    output logic start_hit
);
    localparam logic [CNT_W-1:0] APPLY_AT = CNT_W'(APPLY_EDGE - 1);
    localparam logic [CNT_W-1:0] START_AT = CNT_W'(START_EDGE - 1);

    logic             sck_q;
    logic [CNT_W-1:0] cnt;
    logic             fall;
    logic             live;

    assign fall      = sck_q & ~sck;
    assign live      = fall & ~cs_n & ~hold;
    assign apply_hit = live && (cnt == APPLY_AT);
    assign start_hit = live && (cnt == START_AT);

    // Remember the previous serial-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck;
    end

    // Count edges in the frame; clear outside a frame or while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (cs_n || hold)           cnt <= '0;
        else if (fall && (cnt != '1))    cnt <= cnt + 1'b1;
    end

    a_r10_frame_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (cnt == '0));
    a_r9_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !apply_hit);
endmodule

// File: rtl/azc_half_timer.sv
// Times one half-conversion: BASE << osr_sel clocks while run is high.
// Assumes osr_sel is stable for the whole run.
module azc_half_timer #(
    parameter int OSR_W = 3,
    parameter int BASE  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [OSR_W-1:0] osr_sel,
    output logic             done
);
    localparam int MAX_LEN = BASE << ((1 << OSR_W) - 1);
    localparam int T_W     = $clog2(MAX_LEN + 1);

    logic [T_W-1:0] tcnt;
    logic [T_W-1:0] len;

    assign len  = T_W'(BASE) << osr_sel;
    assign done = run && (tcnt == len - T_W'(1));

    // Advance within a half, restart at its end or when not running.
    always_ff @(posedge clk) begin
        if (!rst_n)           tcnt <= '0;
        else if (!run || done) tcnt <= '0;
        else                  tcnt <= tcnt + 1'b1;
    end

    a_r4_run_starts_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (tcnt == '0));
endmodule

// File: rtl/azc_chop_diff.sv
// Pairs consecutive half-results and emits their sign-corrected difference.
// Each input carries the polarity it was taken with; clear drops history.
module azc_chop_diff #(
    parameter int DW = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_data,
    input  logic                 in_pol,
    output logic                 res_valid,
    output logic signed [DW:0]   res_data
);
    logic signed [DW:0] prev;
    logic signed [DW:0] cur;
    logic               prev_pol;
    logic               have;

    assign cur = {in_data[DW-1], in_data};

    // Keep the last half-result and form the difference on each new one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= '0; prev_pol <= 1'b0; have <= 1'b0;
            res_valid <= 1'b0; res_data <= '0;
        end else begin
            res_valid <= 1'b0;
            if (clear) begin
                have <= 1'b0;
            end else if (in_valid) begin
                if (have) begin
                    res_valid <= 1'b1;
                    res_data  <= prev_pol ? (cur - prev) : (prev - cur);
                end
                prev     <= cur;
                prev_pol <= in_pol;
                have     <= 1'b1;
            end
        end
    end

    a_r6_result_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(in_valid));
endmodule

// File: rtl/azc_chop_sequencer.sv
// Top of the chopped conversion sequencer. Applies channel pairs at the
// apply edge, starts conversions at the start edge, swaps polarity at each
// half end and collects the two-phase difference.
// Assumes each half-result arrives before the following half ends.
module azc_chop_sequencer
    import azc_pkg::*;
#(
    parameter int CH_W      = 2,
    parameter int DW        = 24,
    parameter int OSR_W     = 3,
    parameter int HALF_BASE = 16,
    parameter int SET_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 sck,
    input  logic                 cfg_wr,
    input  logic [CH_W-1:0]      cfg_chan,
    input  logic                 cfg_dbl,
    input  logic [OSR_W-1:0]     cfg_osr,
    input  logic [SET_W-1:0]     settle_cycles,
    input  logic                 half_valid,
    input  logic signed [DW-1:0] half_data,
    output logic [CH_W-1:0]      mux_chan,
    output logic                 mux_swap,
    output logic                 busy,
    output logic                 half_run,
    output logic                 half_done,
    output logic                 res_valid,
    output logic signed [DW:0]   res_data
);
    seq_state_t       state;
    logic [CH_W-1:0]  pend_chan;
    logic [OSR_W-1:0] osr_q;
    logic [SET_W-1:0] scnt;
    logic             mode_q;
    logic             second;
    logic             pol_end;
    logic             apply_hit;
    logic             start_hit;
    logic             tdone;

    assign busy     = (state == ST_HALF) || (state == ST_SETTLE_MID) || (state == ST_WAIT_RES);
    assign half_run = (state == ST_HALF);

    azc_frame_watch #(.CNT_W(6), .APPLY_EDGE(13), .START_EDGE(32)) u_frame (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold(busy),
        .apply_hit(apply_hit), .start_hit(start_hit)
    );

    azc_half_timer #(.OSR_W(OSR_W), .BASE(HALF_BASE)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(half_run), .osr_sel(osr_q), .done(tdone)
    );

    azc_chop_diff #(.DW(DW)) u_diff (
        .clk(clk), .rst_n(rst_n), .clear(state == ST_IDLE),
        .in_valid(half_valid), .in_data(half_data), .in_pol(pol_end),
        .res_valid(res_valid), .res_data(res_data)
    );

    // Sequence conversions and drive the multiplexer lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; pend_chan <= '0; mux_chan <= '0; mux_swap <= 1'b0;
            osr_q <= '0; scnt <= '0; mode_q <= 1'b0; second <= 1'b0;
            pol_end <= 1'b0; half_done <= 1'b0;
        end else begin
            half_done <= 1'b0;
            if (cfg_wr) pend_chan <= cfg_chan;
            if (apply_hit && (pend_chan != mux_chan)) begin
                mux_chan <= pend_chan;
                mux_swap <= 1'b0;
            end
            case (state)
                ST_IDLE: if (start_hit) begin
                    state  <= ST_HALF;
                    second <= 1'b0;
                    mode_q <= cfg_dbl;
                    osr_q  <= cfg_osr;
                end
                ST_HALF: if (tdone) begin
                    half_done <= 1'b1;
                    pol_end   <= mux_swap;
                    mux_swap  <= ~mux_swap;
                    second    <= 1'b1;
                    if (second)      state <= ST_WAIT_RES;
                    else if (mode_q) begin
                        state <= ST_SETTLE_MID;
                        scnt  <= settle_cycles;
                    end
                end
                ST_SETTLE_MID: begin
                    if (scnt == '0) state <= ST_HALF;
                    else            scnt  <= scnt - 1'b1;
                end
                ST_WAIT_RES: if (res_valid) begin
                    state <= mode_q ? ST_SETTLE_NEXT : ST_IDLE;
                    scnt  <= settle_cycles;
                end
                ST_SETTLE_NEXT: begin
                    if (!cs_n)            state <= ST_IDLE;
                    else if (scnt == '0)  state <= ST_HALF;
                    else                  scnt  <= scnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    a_r9_chan_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(mux_chan));
    a_r5_swap_flips_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        half_done |-> (mux_swap != pol_end));
    a_r9_result_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> busy);
    a_r3_run_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start_hit && (state == ST_IDLE)) |=> half_run);
endmodule

// File: tb/azc_chop_sequencer_test.sv
module azc_chop_sequencer_test;
    localparam int CH_W = 2, DW = 24, OSR_W = 3, SET_W = 8;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0;
    logic cfg_wr = 1'b0, cfg_dbl = 1'b0, half_valid = 1'b0;
    logic [CH_W-1:0] cfg_chan = '0;
    logic [OSR_W-1:0] cfg_osr = '0;
    logic [SET_W-1:0] settle_cycles = '0;
    logic signed [DW-1:0] half_data = '0;
    logic [CH_W-1:0] mux_chan;
    logic mux_swap, busy, half_run, half_done, res_valid;
    logic signed [DW:0] res_data;

    azc_chop_sequencer uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .cfg_wr(cfg_wr),
        .cfg_chan(cfg_chan), .cfg_dbl(cfg_dbl), .cfg_osr(cfg_osr),
        .settle_cycles(settle_cycles), .half_valid(half_valid), .half_data(half_data),
        .mux_chan(mux_chan), .mux_swap(mux_swap), .busy(busy), .half_run(half_run),
        .half_done(half_done), .res_valid(res_valid), .res_data(res_data)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    longint exp_q[$];
    bit b_pol, b_have, b_prev_pol, pend_pol;
    longint b_prev;
    int half_k = 0, dly = 0, n_res = 0, n_hd = 0, n_run = 0, n_gap = 0, cur_run = 0, cur_low = 0;
    bit swaplog[16];
    int run_len[16];
    int gap_len[16];

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint mkval(input int k);
        return longint'(((k * 7919) % 9001) - 4500) * 37;
    endfunction

    task automatic track(input bit pol0);
        b_pol = pol0; b_have = 0; n_run = 0; n_gap = 0; n_hd = 0; n_res = 0; cur_low = 0;
    endtask

    task automatic sck_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            sck = 1'b1; repeat (4) @(negedge clk);
            sck = 1'b0; repeat (4) @(negedge clk);
        end
    endtask

    task automatic write_chan(input logic [CH_W-1:0] c);
        @(negedge clk); cfg_wr = 1'b1; cfg_chan = c;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    // Decimator model and scoreboard driver: answer each half end with a value.
    initial forever begin
        @(negedge clk);
        half_valid = 1'b0;
        if (rst_n && half_done) begin
            pend_pol = b_pol; b_pol = ~b_pol; dly = 3;
            if (n_hd < 16) swaplog[n_hd] = mux_swap;
            n_hd++;
        end else if (dly > 0) begin
            dly--;
            if (dly == 0) begin
                longint v;
                v = mkval(half_k); half_k++;
                half_valid = 1'b1; half_data = DW'(v);
                if (b_have) exp_q.push_back(b_prev_pol ? (v - b_prev) : (b_prev - v));
                b_prev = v; b_prev_pol = pend_pol; b_have = 1;
            end
        end
    end

    // Monitor: log run and gap lengths, pop and compare results.
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (half_run) begin
                if (cur_run == 0 && n_run > 0 && n_gap < 16) begin gap_len[n_gap] = cur_low; n_gap++; end
                cur_run++; cur_low = 0;
            end else begin
                if (cur_run > 0 && n_run < 16) begin run_len[n_run] = cur_run; n_run++; end
                cur_run = 0; cur_low++;
            end
            if (res_valid) begin
                n_res++;
                if (exp_q.size() == 0) check(0, "R6 unexpected result", longint'(res_data), 0);
                else begin
                    longint e;
                    e = exp_q.pop_front();
                    check(longint'(res_data) == e, "R6 result value", longint'(res_data), e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(negedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R9 watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        check(mux_chan == 0, "R1 chan", mux_chan, 0);
        check(mux_swap == 0, "R1 swap", mux_swap, 0);
        check(busy == 0 && half_run == 0 && res_valid == 0, "R1 flags", busy, 0);
        rst_n = 1'b1; settle_cycles = 8'd10;

        // Single-rate conversion with a channel change.
        write_chan(2); cfg_dbl = 0; cfg_osr = 1; track(0);
        cs_n = 0; repeat (2) @(negedge clk);
        sck_pulses(12);
        check(mux_chan == 0, "R2 before 13th edge", mux_chan, 0);
        sck_pulses(1);
        check(mux_chan == 2, "R2 at 13th edge", mux_chan, 2);
        check(mux_swap == 0, "R2 swap cleared", mux_swap, 0);
        sck_pulses(18);
        check(busy == 0, "R3 no start before 32nd", busy, 0);
        sck_pulses(1);
        check(busy == 1 && half_run == 1, "R3 start", busy, 1);
        cs_n = 1;
        while (busy) @(negedge clk);
        repeat (5) @(negedge clk);
        check(n_run == 1 && run_len[0] == 64, "R4 1x run length", run_len[0], 64);
        check(n_hd == 2 && swaplog[0] == 1, "R5 mid swap", swaplog[0], 1);
        check(swaplog[1] == 0, "R5 end swap", swaplog[1], 0);
        check(n_res == 1, "R5 one result", n_res, 1);
        check(exp_q.size() == 0, "R6 all results seen", exp_q.size(), 0);

        // Edges during busy are ignored.
        cfg_osr = 3; track(0);
        cs_n = 0; sck_pulses(32); cs_n = 1;
        write_chan(1);
        cs_n = 0; sck_pulses(20); cs_n = 1;
        check(busy == 1 && mux_chan == 2, "R9 no apply while busy", mux_chan, 2);
        while (busy) @(negedge clk);
        repeat (5) @(negedge clk);
        check(mux_chan == 2, "R9 chan after busy", mux_chan, 2);
        check(run_len[0] == 256 && n_res == 1, "R4 osr3 run length", run_len[0], 256);

        // Split frame, then double-rate stream.
        cfg_dbl = 1; cfg_osr = 0; track(0);
        cs_n = 0; sck_pulses(10); cs_n = 1; repeat (3) @(negedge clk);
        cs_n = 0; sck_pulses(3);
        check(mux_chan == 2, "R10 split frame no apply", mux_chan, 2);
        sck_pulses(10);
        check(mux_chan == 1, "R10 13th edge of new frame", mux_chan, 1);
        sck_pulses(19); cs_n = 1;
        while (n_res < 3) @(negedge clk);
        cs_n = 0;
        repeat (100) @(negedge clk);
        cs_n = 1; repeat (2) @(negedge clk);
        check(n_hd == 4 && n_run == 4, "R8 halves in stream", n_hd, 4);
        check(n_res == 3, "R8 results in stream", n_res, 3);
        check(busy == 0, "R8 stream stopped", busy, 0);
        check(run_len[0] == 16 && run_len[1] == 16 && run_len[3] == 16, "R4 2x half length", run_len[1], 16);
        check(gap_len[0] == 11, "R7 settle gap", gap_len[0], 11);
        check(swaplog[0] == 1 && swaplog[1] == 0 && swaplog[2] == 1 && swaplog[3] == 0,
              "R7 swap per half", {swaplog[0], swaplog[1], swaplog[2], swaplog[3]}, 4'b1010);
        check(exp_q.size() == 0, "R6 stream results seen", exp_q.size(), 0);

        // Write colliding with the 13th edge waits a frame.
        cs_n = 0; sck_pulses(12);
        sck = 1; repeat (4) @(negedge clk);
        sck = 0; cfg_wr = 1; cfg_chan = 3;
        @(negedge clk); cfg_wr = 0; repeat (3) @(negedge clk);
        check(mux_chan == 1, "R2 collision held", mux_chan, 1);
        sck_pulses(5); cs_n = 1; repeat (3) @(negedge clk);
        check(busy == 0, "R3 short frame no start", busy, 0);
        cs_n = 0; sck_pulses(13); cs_n = 1;
        check(mux_chan == 3, "R2 collision applied next frame", mux_chan, 3);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule